// File: doc/BRIEF.md
# Staggered Frequency Word Loader

This block takes a tuning word that an outside agent writes with its own strobe, and moves it into the local clock domain. The word goes to an accumulator that is pipelined in byte-wide slices. The word arrives on a bus with a write strobe that is not related to the local clock. The rising edge of that strobe latches the bus into a holding register. The strobe itself then passes through a short synchronizer. The first local-clock cycle in which the synchronized strobe is high, after having been low, produces one load pulse.

That pulse travels down a shift chain with one tap per slice. Each tap copies its own slice of the holding register into the output. The lowest slice is copied first and each higher slice one cycle later. As a result, a slice of the downstream carry-pipelined adder switches to the new increment in the same cycle that its carry from the slice below reflects the new value.

The writer must leave the holding register alone until the last slice has been copied. A second strobe edge inside that window is outside the contract.

Top module: `freq_word_stager`

## Requirements
- R1: While reset is high and in the first cycle after it falls, every bit of `wordOut` is zero.
- R2: The holding register captures `wordIn` only at a rising edge of `wrStrobe`. Changes on `wordIn` after that edge do not reach `wordOut`.
- R3: Call the first rising clock edge after the strobe rises edge 1. With the default synchronizer depth of 2, slice 0 (`wordOut[7:0]`) shows the new value just after edge 4, which is edge SYNC_DEPTH+2.
- R4: Slice i (`wordOut[8*i+7:8*i]`) takes its new value exactly one cycle after slice i-1, so slice 3 (`wordOut[31:24]`) updates just after edge 7.
- R5: A strobe that stays high for many cycles yields one load sequence only. A falling edge of the strobe neither captures nor updates.
- R6: A slice whose load pulse is not active keeps its previous value, so during a sequence the higher slices still show the old word.
- R7: After a complete sequence, `wordOut` equals the captured word bit for bit, with slice 0 in the least significant position.
- R8: A reset asserted in the middle of a sequence clears `wordOut` and the pulse chain. No slice updates after reset is released until a new strobe rising edge occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local clock |
| rst | input | 1 | Synchronous active-high reset |
| wrStrobe | input | 1 | Write strobe, asynchronous to clk; a rising edge captures wordIn |
| wordIn | input | WORD_W (32) | Frequency word from the writer |
| wordOut | output | WORD_W (32) | Synchronized frequency word, updated slice by slice |

## Verification
The bench builds the block with its defaults: a 32-bit word, 8-bit slices and a two-stage synchronizer. This gives four slices, so the full stagger from slice 0 at edge 4 to slice 3 at edge 7 can be observed cycle by cycle. Four slices are enough to cover both boundary slices and the interior ones. The two-stage synchronizer fixes the latency that the expected-value function assumes. Random words, strobe phases and strobe lengths are combined with all-zero and all-one words, a repeated word, a long-held strobe and a reset in the middle of a sequence.

// File: rtl/fwl_pkg.sv
`timescale 1ns/1ps
package fwl_pkg;
  localparam int DEF_WORD_W     = 32;
  localparam int DEF_SLICE_W    = 8;
  localparam int DEF_SYNC_DEPTH = 2;

  // number of slices a word splits into
  function automatic int sliceCount(input int wordW, input int sliceW);
    return wordW / sliceW;
  endfunction
endpackage

// File: rtl/fwl_sync.sv
`timescale 1ns/1ps
module fwl_sync #(
  parameter int SYNC_DEPTH = fwl_pkg::DEF_SYNC_DEPTH
) (
  input  logic clk,
  input  logic rst,
  input  logic asyncIn,
  output logic syncLevel,
  output logic riseSeen
);
  logic [SYNC_DEPTH-1:0] stageQ;
  logic                  prevLevel;

  always_ff @(posedge clk) begin
    if (rst) begin
      stageQ    <= '0;
      prevLevel <= 1'b0;
    end else begin
      stageQ    <= {stageQ[SYNC_DEPTH-2:0], asyncIn};
      prevLevel <= stageQ[SYNC_DEPTH-1];
    end
  end

  assign syncLevel = stageQ[SYNC_DEPTH-1];
  assign riseSeen  = stageQ[SYNC_DEPTH-1] & ~prevLevel;
endmodule

// File: rtl/fwl_ctrl.sv
`timescale 1ns/1ps
module fwl_ctrl #(
  parameter int NUM_SLICES = 4,
  parameter int SYNC_DEPTH = fwl_pkg::DEF_SYNC_DEPTH
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wrStrobe,
  output logic                  syncLevel,
  output logic [NUM_SLICES-1:0] sliceLoad
);
  logic riseSeen;

  fwl_sync #(.SYNC_DEPTH(SYNC_DEPTH)) uSync (
    .clk      (clk),
    .rst      (rst),
    .asyncIn  (wrStrobe),
    .syncLevel(syncLevel),
    .riseSeen (riseSeen)
  );

  // one pulse walks from slice 0 upward, one slice per cycle
  always_ff @(posedge clk) begin
    if (rst) sliceLoad <= '0;
    else     sliceLoad <= {sliceLoad[NUM_SLICES-2:0], riseSeen};
  end
endmodule

// File: rtl/fwl_datapath.sv
`timescale 1ns/1ps
module fwl_datapath #(
  parameter int WORD_W  = fwl_pkg::DEF_WORD_W,
  parameter int SLICE_W = fwl_pkg::DEF_SLICE_W,
  localparam int NUM_SLICES = fwl_pkg::sliceCount(WORD_W, SLICE_W)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wrStrobe,
  input  logic [WORD_W-1:0]     wordIn,
  input  logic [NUM_SLICES-1:0] sliceLoad,
  output logic [WORD_W-1:0]     wordOut
);
  logic [WORD_W-1:0]  holdReg;
  logic [SLICE_W-1:0] sliceQ [NUM_SLICES];

  // writer-side capture, clocked by the strobe itself
  always_ff @(posedge wrStrobe) holdReg <= wordIn;

  for (genvar i = 0; i < NUM_SLICES; i++) begin : gSlice
    always_ff @(posedge clk) begin
      if (rst)               sliceQ[i] <= '0;
      else if (sliceLoad[i]) sliceQ[i] <= holdReg[i*SLICE_W +: SLICE_W];
    end
    assign wordOut[i*SLICE_W +: SLICE_W] = sliceQ[i];
  end
endmodule

// File: rtl/freq_word_stager.sv
`timescale 1ns/1ps
module freq_word_stager #(
  parameter int WORD_W     = fwl_pkg::DEF_WORD_W,
  parameter int SLICE_W    = fwl_pkg::DEF_SLICE_W,
  parameter int SYNC_DEPTH = fwl_pkg::DEF_SYNC_DEPTH
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrStrobe,
  input  logic [WORD_W-1:0] wordIn,
  output logic [WORD_W-1:0] wordOut
);
  localparam int NUM_SLICES = fwl_pkg::sliceCount(WORD_W, SLICE_W);

  logic                  syncLevel;
  logic [NUM_SLICES-1:0] sliceLoad;

  fwl_ctrl #(.NUM_SLICES(NUM_SLICES), .SYNC_DEPTH(SYNC_DEPTH)) uCtrl (
    .clk      (clk),
    .rst      (rst),
    .wrStrobe (wrStrobe),
    .syncLevel(syncLevel),
    .sliceLoad(sliceLoad)
  );

  fwl_datapath #(.WORD_W(WORD_W), .SLICE_W(SLICE_W)) uData (
    .clk      (clk),
    .rst      (rst),
    .wrStrobe (wrStrobe),
    .wordIn   (wordIn),
    .sliceLoad(sliceLoad),
    .wordOut  (wordOut)
  );
endmodule

// File: rtl/fwl_checker.sv
`timescale 1ns/1ps
module fwl_checker #(
  parameter int WORD_W  = fwl_pkg::DEF_WORD_W,
  parameter int SLICE_W = fwl_pkg::DEF_SLICE_W,
  localparam int NUM_SLICES = fwl_pkg::sliceCount(WORD_W, SLICE_W)
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  syncLevel,
  input logic [NUM_SLICES-1:0] sliceLoad,
  input logic [WORD_W-1:0]     wordOut
);
  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (wordOut == '0));

  assert_single_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(sliceLoad));

  assert_first_slice_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(syncLevel) |=> sliceLoad[0]);

  for (genvar i = 0; i < NUM_SLICES; i++) begin : gChk
    assert_slice_hold_R6: assert property (@(posedge clk) disable iff (rst)
      !sliceLoad[i] |=> $stable(wordOut[i*SLICE_W +: SLICE_W]));
    if (i > 0) begin : gOrder
      assert_stagger_R4: assert property (@(posedge clk) disable iff (rst)
        sliceLoad[i] |-> $past(sliceLoad[i-1]));
    end
  end
endmodule

bind freq_word_stager fwl_checker #(.WORD_W(WORD_W), .SLICE_W(SLICE_W)) uChk (
  .clk      (clk),
  .rst      (rst),
  .syncLevel(syncLevel),
  .sliceLoad(sliceLoad),
  .wordOut  (wordOut)
);

// File: tb/sim_freq_word_stager.sv
`timescale 1ns/1ps
module sim_freq_word_stager;
  localparam int WORD_W = 32;
  localparam int SLICE_W = 8;
  localparam int SYNC_DEPTH = 2;
  localparam int NSL = WORD_W / SLICE_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wrStrobe = 1'b0;
  logic [WORD_W-1:0] wordIn = '0;
  logic [WORD_W-1:0] wordOut;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  logic [WORD_W-1:0] model = '0;

  always #2 clk = ~clk;

  freq_word_stager #(.WORD_W(WORD_W), .SLICE_W(SLICE_W), .SYNC_DEPTH(SYNC_DEPTH)) u0 (
    .clk(clk), .rst(rst), .wrStrobe(wrStrobe), .wordIn(wordIn), .wordOut(wordOut)
  );

  // expected output k edges after the strobe rose (R3, R4, R6)
  function automatic logic [WORD_W-1:0] expectAt(input logic [WORD_W-1:0] oldW,
                                                 input logic [WORD_W-1:0] newW,
                                                 input int k);
    logic [WORD_W-1:0] r = oldW;
    for (int i = 0; i < NSL; i++)
      if (k >= SYNC_DEPTH + 2 + i) r[i*SLICE_W +: SLICE_W] = newW[i*SLICE_W +: SLICE_W];
    return r;
  endfunction

  task automatic check(input string tag, input logic [WORD_W-1:0] act, input logic [WORD_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
  endtask

  // one write: strobe rises before edge 1, wordIn disturbed afterward
  task automatic writeWord(input logic [WORD_W-1:0] w, input int holdCycles,
                           input logic [WORD_W-1:0] lateWord);
    @(negedge clk);
    wordIn = w;
    #0.5 wrStrobe = 1'b1;
    for (int k = 1; k <= 10; k++) begin
      @(posedge clk);
      #1;
      if (k == 1) wordIn = lateWord;            // R2: must not reach output
      check("R3_R4_R6 stagger", wordOut, expectAt(model, w, k));
      if (k == holdCycles) wrStrobe = 1'b0;
    end
    model = w;
    wrStrobe = 1'b0;
    idle(SYNC_DEPTH + 3);
    #1 check("R7 full word", wordOut, model);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    idle(3);
    #1 check("R1 during reset", wordOut, '0);
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #1 check("R1 after reset", wordOut, '0);

    // directed corners
    writeWord(32'hFFFF_FFFF, 2, 32'h0);
    writeWord(32'h0000_0000, 9, 32'hFFFF_FFFF);
    writeWord(32'h0403_0201, 1, 32'hDEAD_BEEF);   // R7 slice order
    writeWord(32'h0403_0201, 5, 32'h1111_1111);   // same word again

    // R5: long-held strobe, then falling edge with a new bus value
    @(negedge clk); wordIn = 32'hA5C3_1E77; #0.5 wrStrobe = 1'b1;
    idle(30);
    #1 check("R5 held strobe", wordOut, 32'hA5C3_1E77);
    model = 32'hA5C3_1E77;
    wordIn = 32'h0BAD_F00D;
    @(negedge clk); wrStrobe = 1'b0;
    for (int k = 0; k < 12; k++) begin
      @(posedge clk); #1 check("R5 falling edge", wordOut, model);
    end

    // R8: reset in the middle of a sequence
    @(negedge clk); wordIn = 32'h1234_5678; #0.5 wrStrobe = 1'b1;
    idle(SYNC_DEPTH + 2);
    #1 check("R8 slice0 before reset", wordOut, {model[31:8], 8'h78});
    @(negedge clk); rst = 1'b1;
    idle(2);
    @(negedge clk); rst = 1'b0; wrStrobe = 1'b0;
    for (int k = 0; k < 12; k++) begin
      @(posedge clk); #1 check("R8 cleared", wordOut, '0);
    end
    model = '0;

    // random words, strobe lengths and disturbances
    for (int n = 0; n < 40; n++)
      writeWord($urandom, 1 + ($urandom % 9), $urandom);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule